// File: doc/BRIEF.md
# Position-Modulated Pulse Scheduler with Delay Scrambling

This block sets the pulse timing for a pulsed ultra-wideband transmitter that carries data in pulse position. A free-running frame counter splits time into frames whose length is a programmable number of clock cycles. At the first cycle of each frame the block offers to take one data bit over a valid/ready handshake. The bit selects one of two slots: the early slot just after frame start, or the late slot at half the frame. The block then fires a one-cycle trigger in that slot.

Each frame that carries a bit also draws one bit from an internal 7-bit pseudo-random sequence. That bit is output as a scramble flag, which tells the delay line to shift the pulse by half an RF period so that the transmitted spectrum has no discrete lines. The pulse itself is never inverted. Around each pulse the block opens a short window. During the window it enables the 30 combined taps of a 32-tap mask and opens the feedback stage that would otherwise close the delay line into a ring.

Top module: `ppm_pulse_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `trig_o` is 0, `tap_mask_o` is 0, `fb_break_o` is 0, `scramble_o` is 0 and `bit_ready_o` is 1.
- R2: The effective frame length is `frame_len_i` when that value is at least MIN_LEN, and MIN_LEN otherwise. MIN_LEN is the larger of 4 and twice PULSE_W, which gives 8 with the default parameters. `bit_ready_o` is high for one cycle at the start of each frame and nowhere else in the frame.
- R3: A bit is taken only in a cycle where both `bit_ready_o` and `bit_valid_i` are high.
- R4: Let H be the cycle in which a bit is taken and L the effective length of that frame. If the bit is 0, `trig_o` is high in cycle H+1 only. If the bit is 1, `trig_o` is high in cycle H+1+(L>>1) only.
- R5: If `bit_valid_i` is low at the start of a frame, that frame produces no trigger and no window, `scramble_o` is 0 for the frame, and the sequence does not advance.
- R6: The sequence state s is 7 bits wide and is reset to 7'h01. At each taken bit, the scramble bit is s[6], and the state then becomes {s[5:0], s[6]^s[5]}.
- R7: `scramble_o` takes the scramble bit of the frame in the cycle after the frame start, and holds it until the next frame start.
- R8: The pulse window lasts PULSE_W cycles and begins in the trigger cycle. During the window `tap_mask_o[29:0]` are all 1; outside it they are all 0. `tap_mask_o[31:30]` are always 0.
- R9: `fb_break_o` is high exactly during the pulse window.
- R10: A change of `frame_len_i` in the middle of a frame has no effect until the next frame start. The current frame's length and slot position stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_len_i | input | 8 | Requested frame length in cycles, sampled at frame start |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_data_i | input | 1 | Data bit value; 0 selects the early slot, 1 the late slot |
| bit_ready_o | output | 1 | Frame start; the offered bit is taken this cycle |
| trig_o | output | 1 | One-cycle pulse trigger |
| scramble_o | output | 1 | Half-RF-period delay request for this frame's pulse |
| tap_mask_o | output | 32 | Delay-line taps routed to the edge combiner |
| fb_break_o | output | 1 | Opens the ring feedback stage during the pulse window |

## Verification
The hardest situation to reach is a late-slot pulse in one frame followed by a shortened next frame. In that case the window must close before the new frame's early slot, while `frame_len_i` is changing underneath. The stimulus changes the requested length at random cycles, often to values below the minimum, so that length changes land both in the middle of a frame and exactly at frame start. It also mixes frames with no offered bit among frames with random bits. That mix exercises the rule that the sequence holds still on empty frames, together with long runs of early and late slots.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  localparam int SEQ_W = 7;

  // advance the 7-bit sequence (x^7 + x^6 + 1)
  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[SEQ_W-1] ^ s[SEQ_W-2]};
  endfunction

  // clamp a requested frame length to the minimum
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned min_len);
    return (req < min_len) ? min_len : req;
  endfunction

  // slot offset of the late slot
  function automatic int unsigned late_offset(input int unsigned len);
    return len >> 1;
  endfunction

  // tap mask with the low `live` bits set
  function automatic logic [31:0] live_taps(input int unsigned live);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) m[i] = (i < live);
    return m;
  endfunction

endpackage

// File: rtl/ppm_frame_timer.sv
module ppm_frame_timer
  import ppm_pkg::*;
#(
  parameter int CW      = 8,
  parameter int MIN_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] frame_len_i,
  output logic          start_o,
  output logic [CW-1:0] pos_o,
  output logic [CW-1:0] half_o
);

  logic [CW-1:0] pos_q, len_q, cur_len, req_len;

  assign start_o = (pos_q == '0);
  assign req_len = CW'(clamp_len(int'(frame_len_i), MIN_LEN));
  assign cur_len = start_o ? req_len : len_q;
  assign pos_o   = pos_q;
  assign half_o  = CW'(late_offset(int'(cur_len)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= CW'(MIN_LEN);
    end else begin
      pos_q <= (pos_q == cur_len - 1'b1) ? '0 : pos_q + 1'b1;
      if (start_o) len_q <= req_len;
    end
  end

  // R2
  len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q >= CW'(MIN_LEN));

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |=> $stable(len_q));

endmodule

// File: rtl/ppm_prbs7.sv
module ppm_prbs7
  import ppm_pkg::*;
#(
  parameter logic [SEQ_W-1:0] SEED = 7'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic bit_o
);

  logic [SEQ_W-1:0] state_q;

  assign bit_o = state_q[SEQ_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     state_q <= SEED;
    else if (adv_i) state_q <= seq_step(state_q);
  end

  // R6
  seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R5
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_q));

endmodule

// File: rtl/ppm_pulse_gate.sv
module ppm_pulse_gate
  import ppm_pkg::*;
#(
  parameter int TAPS    = 32,
  parameter int LIVE    = 30,
  parameter int PULSE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  output logic            trig_o,
  output logic [TAPS-1:0] mask_o,
  output logic            fb_break_o
);

  localparam int WW = $clog2(PULSE_W + 1);
  localparam logic [31:0] LIVE_MASK = live_taps(LIVE);

  logic [WW-1:0] win_q;
  logic          trig_q, win_on;

  assign win_on     = (win_q != '0);
  assign trig_o     = trig_q;
  assign fb_break_o = win_on;

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_tap
      if (g < LIVE) begin : g_live
        assign mask_o[g] = win_on & LIVE_MASK[g];
      end else begin : g_dead
        assign mask_o[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= fire_i;
      if (fire_i)      win_q <= WW'(PULSE_W);
      else if (win_on) win_q <= win_q - 1'b1;
    end
  end

  // R8
  dead_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_o[TAPS-1:LIVE] == '0);

  // R9
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_break_o && !trig_o) |-> $past(fb_break_o));

  // R4
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

endmodule

// File: rtl/ppm_pulse_sched.sv
module ppm_pulse_sched
  import ppm_pkg::*;
#(
  parameter int CW      = 8,
  parameter int TAPS    = 32,
  parameter int LIVE    = 30,
  parameter int PULSE_W = 4,
  parameter logic [SEQ_W-1:0] SEED = 7'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   frame_len_i,
  input  logic            bit_valid_i,
  input  logic            bit_data_i,
  output logic            bit_ready_o,
  output logic            trig_o,
  output logic            scramble_o,
  output logic [TAPS-1:0] tap_mask_o,
  output logic            fb_break_o
);

  localparam int MIN_LEN = (2 * PULSE_W > 4) ? 2 * PULSE_W : 4;

  logic          start, take, seq_bit, fire;
  logic [CW-1:0] pos, half;
  logic          armed_q, bit_q, scr_q;

  ppm_frame_timer #(.CW(CW), .MIN_LEN(MIN_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_len_i(frame_len_i),
    .start_o(start), .pos_o(pos), .half_o(half)
  );

  assign take = start & bit_valid_i;

  ppm_prbs7 #(.SEED(SEED)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv_i(take), .bit_o(seq_bit)
  );

  assign fire = (take & ~bit_data_i) |
                (~start & armed_q & bit_q & (pos == half));

  ppm_pulse_gate #(.TAPS(TAPS), .LIVE(LIVE), .PULSE_W(PULSE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .fire_i(fire),
    .trig_o(trig_o), .mask_o(tap_mask_o), .fb_break_o(fb_break_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bit_q   <= 1'b0;
      scr_q   <= 1'b0;
    end else if (start) begin
      armed_q <= take;
      bit_q   <= bit_data_i;
      scr_q   <= take & seq_bit;
    end
  end

  assign bit_ready_o = start;
  assign scramble_o  = scr_q;

  // R4
  trig_off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !bit_ready_o);

  // R7
  scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ready_o |=> $stable(scramble_o));

  // R5
  empty_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready_o && !bit_valid_i) |=> !scramble_o);

  // R6
  scr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready_o && bit_valid_i) |=> scramble_o == $past(seq_bit));

endmodule

// File: tb/test_ppm_pulse_sched.sv
module test_ppm_pulse_sched;

  localparam int CW = 8, PW = 4, MINL = 8, NCYC = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] frame_len = 8'd10;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic bit_ready, trig, scr, fbk;
  logic [31:0] mask;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ppm_pulse_sched i_ppm_pulse_sched (
    .clk(clk), .rst_n(rst_n), .frame_len_i(frame_len),
    .bit_valid_i(bit_valid), .bit_data_i(bit_data),
    .bit_ready_o(bit_ready), .trig_o(trig), .scramble_o(scr),
    .tap_mask_o(mask), .fb_break_o(fbk)
  );

  function automatic int ref_len(int req);
    return (req < MINL) ? MINL : req;
  endfunction

  function automatic logic [6:0] ref_step(logic [6:0] s);
    logic fb;
    fb = ((s >> 6) & 1) != ((s >> 5) & 1);
    return ((s << 1) & 7'h7F) | 7'(fb);
  endfunction

  function automatic logic [31:0] ref_mask(bit on);
    return on ? ((32'd1 << 30) - 32'd1) : 32'd0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference state
  int mpos = 0, mlen = MINL, trig_at = -1000, cyc = 0;
  logic [6:0] mseq = 7'h01;
  bit exp_scr = 0;

  task automatic drive(int c);
    int r;
    // directed phases, then random
    if (c < 200) begin
      bit_valid = 1'b1; bit_data = c[3]; frame_len = 8'd12;
    end else if (c < 300) begin
      bit_valid = 1'b0; frame_len = 8'd0;          // below minimum, empty frames
    end else if (c < 700) begin
      bit_valid = 1'b1; bit_data = 1'b1; frame_len = 8'(c % 3 == 0 ? 9 : 3);
    end else if (c < 1100) begin
      bit_valid = 1'b1; bit_data = 1'b0; frame_len = 8'd255;
    end else begin
      r = int'($urandom() % 100);
      bit_valid = (r < 75);
      bit_data = $urandom() % 2;
      if ($urandom() % 5 == 0) frame_len = 8'($urandom() % 24);
    end
  endtask

  initial begin : watchdog
    repeat (NCYC * 3) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, NCYC);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held quiet during reset
    chk(trig == 0 && fbk == 0 && mask == 0 && scr == 0, "R1", "in-reset outputs", {trig, fbk, scr}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      bit win, take;
      if (c != 0) @(negedge clk);
      cyc = c;
      win = (c >= trig_at) && (c < trig_at + PW);
      if (c == 0)
        chk(bit_ready && !trig && !fbk && mask == 0 && !scr, "R1", "first cycle", {bit_ready, trig, fbk, scr}, 4'b1000);
      chk(bit_ready == (mpos == 0), "R2", "ready at frame start", bit_ready, mpos == 0);
      chk(trig == (c == trig_at), "R4", "trigger cycle", trig, c == trig_at);
      chk(mask == ref_mask(win), "R8", "tap mask", mask, ref_mask(win));
      chk(fbk == win, "R9", "feedback break", fbk, win);
      chk(scr == exp_scr, "R7", "scramble flag", scr, exp_scr);
      drive(c);
      // next-state prediction for the coming edge
      if (mpos == 0) begin
        mlen = ref_len(int'(frame_len));
        take = bit_valid;                               // R3
        if (take) begin
          trig_at = c + 1 + (bit_data ? (mlen >> 1) : 0);
          exp_scr = mseq[6];                           // R6
          mseq = ref_step(mseq);
        end else begin
          exp_scr = 0;                                 // R5
        end
      end
      // R10: mid-frame length changes ignored via mlen held
      mpos = (mpos == mlen - 1) ? 0 : mpos + 1;
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule